// File: doc/BRIEF.md
# Standby-Aware I/O Pad Controller

This block sits between the port and peripheral logic of a microcontroller and a group of general-purpose I/O pads. For every pad it decides what reaches the pad driver, whether the driver is enabled, whether the input gate runs, whether the internal side accepts the pad value, and whether the pull-up is applied. The decision depends on the power state the chip is in: run, sleep, one of three stop-class standby states (stop, watch, timebase-timer), or reset.

When the mode leaves run, the block freezes a copy of the last live output value, output enable and peripheral-select of every pad. Sleep keeps peripheral-driven pads following their still-running peripheral and holds the port-driven ones. The stop-class modes either hold the frozen output or release the drivers to high impedance, picked by a single level-select bit, and cut the input gates off. Interrupt-capable pads can be individually kept listening through stop-class modes. Reset overrides every mode.

Top module: `pad_standby_ctrl`

## Requirements
- R1: In run (mode 0) and not in reset, each pad drives `per_out` when its `per_out_en` bit is 1 and `port_out` otherwise; its output enable is `per_out_en | port_dir` (direction 1 = output).
- R2: In run and sleep, every pad has `pad_gate_en` = 1 and `pad_in_en` = 1, output pads included.
- R3: The held output value, output enable and peripheral-select are loaded on every rising clock edge while the mode is run and reset is low; in any other mode they stay frozen, and on return to run the live values pass again.
- R4: In sleep (mode 1) the output enable is the held one; a pad whose held peripheral-select is 1 drives the live `per_out`, any other pad drives its held value; `pin_hiz_sel` has no effect.
- R5: Mode codes 2 (stop), 3 (watch), 4 (timebase timer) and the unused codes 5 to 7 are stop-class; there, with `pin_hiz_sel` = 0, output value and enable are the held ones and stay unchanged for as long as the mode lasts.
- R6: In a stop-class mode with `pin_hiz_sel` = 1, every output enable is 0.
- R7: In a stop-class mode an input gate is cut off (`pad_gate_en` = 0, `pad_in_en` = 0), except on a pad that is marked interrupt-capable by the `IRQ_PADS` mask and has its `irq_sel` bit at 1, which stays fully enabled (1, 1); an `irq_sel` bit on a pad outside the mask has no effect.
- R8: While `rst` is 1, every pad has output enable 0, output 0, `pad_gate_en` = 1, `pad_in_en` = 0 and pull-up 0, whatever the mode; reset also clears the held values, so a stop-class mode entered straight out of reset drives nothing.
- R9: `pad_pull_en` equals `pull_req` masked by the `PULL_PADS` mask in run and is 0 in every other mode and in reset.
- R10: `pad_out` is 0 on every pad whose `pad_oe` is 0.
- R11: The input state uses three codes per pad as {`pad_gate_en`, `pad_in_en`}: enabled = 11, disabled = 10, cut off = 00; 01 never appears.
- R12: A pad whose peripheral output was disabled in the last run cycle holds the output enable given by `port_dir` through a stop-class mode, even if `per_out_en` is raised again during standby.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the hold register |
| rst | input | 1 | Active-high chip reset, overrides all modes |
| mode | input | 3 | Power state: 0 run, 1 sleep, 2 stop, 3 watch, 4 timebase timer, 5-7 stop-class |
| pin_hiz_sel | input | 1 | Stop-class output choice: 0 hold, 1 high impedance |
| irq_sel | input | NUM_PADS | Per-pad request to stay input-enabled in stop-class modes |
| per_out_en | input | NUM_PADS | Peripheral owns the pad output |
| per_out | input | NUM_PADS | Peripheral output value |
| port_out | input | NUM_PADS | Port data register value |
| port_dir | input | NUM_PADS | Port direction, 1 = output |
| pull_req | input | NUM_PADS | Pull-up request from the port |
| pad_out | output | NUM_PADS | Value to the pad driver |
| pad_oe | output | NUM_PADS | Pad driver enable |
| pad_gate_en | output | NUM_PADS | Input gate enable |
| pad_in_en | output | NUM_PADS | Internal input path enable |
| pad_pull_en | output | NUM_PADS | Pull-up enable |

## Verification
The bench loads one set of live values in run, then enters each mode with different live values so that a design that passes live data instead of the frozen copy, or freezes the wrong cycle, shows a wrong output at once. It separates the two input-off codes, because a design that merges "disabled" into "cut off" would show a dead gate during reset. It sets `irq_sel` on pads outside the interrupt mask, which a design without the mask would leave listening, and re-raises a peripheral enable during stop, which a design following the live enable would drive onto the pad. It enters stop straight out of reset to catch a hold register that keeps pre-reset values.

// File: rtl/pad_ctl_pkg.sv
`timescale 1ns/1ps
package pad_ctl_pkg;

  localparam logic [2:0] MODE_RUN   = 3'd0;
  localparam logic [2:0] MODE_SLEEP = 3'd1;

  // {gate, internal} codes; 2'b01 is illegal
  typedef enum logic [1:0] {
    GATE_CUT     = 2'b00,
    GATE_BLOCKED = 2'b10,
    GATE_OPEN    = 2'b11
  } gate_state_e;

  typedef struct packed {
    logic in_reset;
    logic run;
    logic sleep;
    logic stdby;
    logic hiz;
  } pad_policy_t;

  function automatic logic f_live_out(input logic per_en, input logic per_val,
                                      input logic port_val);
    return per_en ? per_val : port_val;
  endfunction

  function automatic logic f_live_oe(input logic per_en, input logic dir_out);
    return per_en | dir_out;
  endfunction

  function automatic logic f_gate_bit(input gate_state_e g);
    return g[1];
  endfunction

  function automatic logic f_int_bit(input gate_state_e g);
    return g[0];
  endfunction

endpackage

// File: rtl/pad_mode_decode.sv
`timescale 1ns/1ps
module pad_mode_decode
  import pad_ctl_pkg::*;
(
  input  logic        rst,
  input  logic [2:0]  mode,
  input  logic        pin_hiz_sel,
  output pad_policy_t policy,
  output logic        capture_en,
  output logic        stdby_cls
);

  logic is_run;
  logic is_sleep;

  always_comb begin
    is_run    = (mode == MODE_RUN);
    is_sleep  = (mode == MODE_SLEEP);
    stdby_cls = !is_run && !is_sleep;
  end

  always_comb begin
    policy.in_reset = rst;
    policy.run      = is_run && !rst;
    policy.sleep    = is_sleep && !rst;
    policy.stdby    = stdby_cls && !rst;
    policy.hiz      = pin_hiz_sel;
    capture_en      = is_run && !rst;
  end

endmodule

// File: rtl/pad_hold_bank.sv
`timescale 1ns/1ps
module pad_hold_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         capture_en,
  input  logic [W-1:0] live_out,
  input  logic [W-1:0] live_oe,
  input  logic [W-1:0] live_per,
  output logic [W-1:0] held_out,
  output logic [W-1:0] held_oe,
  output logic [W-1:0] held_per
);

  always_ff @(posedge clk) begin
    if (rst) begin
      held_out <= '0;
      held_oe  <= '0;
      held_per <= '0;
    end else if (capture_en) begin
      held_out <= live_out;
      held_oe  <= live_oe;
      held_per <= live_per;
    end
  end

endmodule

// File: rtl/pad_lane.sv
`timescale 1ns/1ps
module pad_lane
  import pad_ctl_pkg::*;
#(
  parameter bit IRQ_CAP  = 1'b0,
  parameter bit PULL_CAP = 1'b0
) (
  input  pad_policy_t policy,
  input  logic        live_out,
  input  logic        live_oe,
  input  logic        per_val,
  input  logic        held_out,
  input  logic        held_oe,
  input  logic        held_per,
  input  logic        irq_keep,
  input  logic        pull_req,
  output logic        pad_out,
  output logic        pad_oe,
  output logic        pad_gate_en,
  output logic        pad_in_en,
  output logic        pad_pull_en
);

  logic        drive_val;
  gate_state_e gate_st;
  logic        keep_listening;

  assign keep_listening = IRQ_CAP && irq_keep;

  always_comb begin
    drive_val = 1'b0;
    pad_oe    = 1'b0;
    gate_st   = GATE_BLOCKED;
    if (policy.in_reset) begin
      drive_val = 1'b0;
      pad_oe    = 1'b0;
      gate_st   = GATE_BLOCKED;
    end else if (policy.run) begin
      drive_val = live_out;
      pad_oe    = live_oe;
      gate_st   = GATE_OPEN;
    end else if (policy.sleep) begin
      drive_val = held_per ? per_val : held_out;
      pad_oe    = held_oe;
      gate_st   = GATE_OPEN;
    end else begin
      drive_val = held_out;
      pad_oe    = policy.hiz ? 1'b0 : held_oe;
      gate_st   = keep_listening ? GATE_OPEN : GATE_CUT;
    end
  end

  assign pad_out     = drive_val & pad_oe;
  assign pad_gate_en = f_gate_bit(gate_st);
  assign pad_in_en   = f_int_bit(gate_st);
  assign pad_pull_en = PULL_CAP && pull_req && policy.run && !policy.in_reset;

endmodule

// File: rtl/pad_standby_ctrl.sv
`timescale 1ns/1ps
module pad_standby_ctrl
  import pad_ctl_pkg::*;
#(
  parameter int                  NUM_PADS  = 8,
  parameter logic [NUM_PADS-1:0] IRQ_PADS  = 8'h12,
  parameter logic [NUM_PADS-1:0] PULL_PADS = 8'h0F
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          mode,
  input  logic                pin_hiz_sel,
  input  logic [NUM_PADS-1:0] irq_sel,
  input  logic [NUM_PADS-1:0] per_out_en,
  input  logic [NUM_PADS-1:0] per_out,
  input  logic [NUM_PADS-1:0] port_out,
  input  logic [NUM_PADS-1:0] port_dir,
  input  logic [NUM_PADS-1:0] pull_req,
  output logic [NUM_PADS-1:0] pad_out,
  output logic [NUM_PADS-1:0] pad_oe,
  output logic [NUM_PADS-1:0] pad_gate_en,
  output logic [NUM_PADS-1:0] pad_in_en,
  output logic [NUM_PADS-1:0] pad_pull_en
);

  pad_policy_t         policy;
  logic                capture_en;
  logic                stdby_cls;
  logic [NUM_PADS-1:0] live_out;
  logic [NUM_PADS-1:0] live_oe;
  logic [NUM_PADS-1:0] held_out;
  logic [NUM_PADS-1:0] held_oe;
  logic [NUM_PADS-1:0] held_per;

  pad_mode_decode u_decode (
    .rst         (rst),
    .mode        (mode),
    .pin_hiz_sel (pin_hiz_sel),
    .policy      (policy),
    .capture_en  (capture_en),
    .stdby_cls   (stdby_cls)
  );

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_live
    assign live_out[i] = f_live_out(per_out_en[i], per_out[i], port_out[i]);
    assign live_oe[i]  = f_live_oe(per_out_en[i], port_dir[i]);
  end

  pad_hold_bank #(.W(NUM_PADS)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .capture_en (capture_en),
    .live_out   (live_out),
    .live_oe    (live_oe),
    .live_per   (per_out_en),
    .held_out   (held_out),
    .held_oe    (held_oe),
    .held_per   (held_per)
  );

  for (genvar i = 0; i < NUM_PADS; i++) begin : g_lane
    pad_lane #(
      .IRQ_CAP  (IRQ_PADS[i]),
      .PULL_CAP (PULL_PADS[i])
    ) u_lane (
      .policy      (policy),
      .live_out    (live_out[i]),
      .live_oe     (live_oe[i]),
      .per_val     (per_out[i]),
      .held_out    (held_out[i]),
      .held_oe     (held_oe[i]),
      .held_per    (held_per[i]),
      .irq_keep    (irq_sel[i]),
      .pull_req    (pull_req[i]),
      .pad_out     (pad_out[i]),
      .pad_oe      (pad_oe[i]),
      .pad_gate_en (pad_gate_en[i]),
      .pad_in_en   (pad_in_en[i]),
      .pad_pull_en (pad_pull_en[i])
    );
  end

endmodule

// File: rtl/pad_standby_ctrl_chk.sv
`timescale 1ns/1ps
module pad_standby_ctrl_chk #(
  parameter int                  NUM_PADS = 8,
  parameter logic [NUM_PADS-1:0] IRQ_PADS = 8'h12
) (
  input logic                clk,
  input logic                rst,
  input logic [2:0]          mode,
  input logic                pin_hiz_sel,
  input logic [NUM_PADS-1:0] irq_sel,
  input logic                stdby_cls,
  input logic [NUM_PADS-1:0] pad_out,
  input logic [NUM_PADS-1:0] pad_oe,
  input logic [NUM_PADS-1:0] pad_gate_en,
  input logic [NUM_PADS-1:0] pad_in_en,
  input logic [NUM_PADS-1:0] pad_pull_en
);

  assert_reset_state_R8: assert property (@(posedge clk)
    rst |-> (pad_oe == '0 && pad_in_en == '0 && pad_gate_en == '1 && pad_pull_en == '0));

  assert_no_int_without_gate_R11: assert property (@(posedge clk)
    (pad_in_en & ~pad_gate_en) == '0);

  assert_hiz_in_standby_R6: assert property (@(posedge clk) disable iff (rst)
    (stdby_cls && pin_hiz_sel) |-> pad_oe == '0);

  assert_gate_cut_R7: assert property (@(posedge clk) disable iff (rst)
    stdby_cls |-> (pad_gate_en & ~(IRQ_PADS & irq_sel)) == '0);

  assert_pull_only_run_R9: assert property (@(posedge clk) disable iff (rst)
    (mode != 3'd0) |-> pad_pull_en == '0);

  assert_out_masked_R10: assert property (@(posedge clk)
    (pad_out & ~pad_oe) == '0);

  assert_held_frozen_R5: assert property (@(posedge clk) disable iff (rst)
    (stdby_cls && $past(stdby_cls) && !$past(rst) && !pin_hiz_sel && !$past(pin_hiz_sel))
      |-> ($stable(pad_oe) && $stable(pad_out)));

endmodule

bind pad_standby_ctrl pad_standby_ctrl_chk #(
  .NUM_PADS (NUM_PADS),
  .IRQ_PADS (IRQ_PADS)
) i_chk (
  .clk         (clk),
  .rst         (rst),
  .mode        (mode),
  .pin_hiz_sel (pin_hiz_sel),
  .irq_sel     (irq_sel),
  .stdby_cls   (stdby_cls),
  .pad_out     (pad_out),
  .pad_oe      (pad_oe),
  .pad_gate_en (pad_gate_en),
  .pad_in_en   (pad_in_en),
  .pad_pull_en (pad_pull_en)
);

// File: tb/test_pad_standby_ctrl.sv
`timescale 1ns/1ps
module test_pad_standby_ctrl;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'd0;
  logic       pin_hiz_sel = 1'b0;
  logic [7:0] irq_sel = '0, per_out_en = '0, per_out = '0, port_out = '0;
  logic [7:0] port_dir = '0, pull_req = '0;
  logic [7:0] pad_out, pad_oe, pad_gate_en, pad_in_en, pad_pull_en;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pad_standby_ctrl i_pad_standby_ctrl (
    .clk(clk), .rst(rst), .mode(mode), .pin_hiz_sel(pin_hiz_sel),
    .irq_sel(irq_sel), .per_out_en(per_out_en), .per_out(per_out),
    .port_out(port_out), .port_dir(port_dir), .pull_req(pull_req),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_gate_en(pad_gate_en),
    .pad_in_en(pad_in_en), .pad_pull_en(pad_pull_en)
  );

  typedef struct packed {
    logic [2:0] md;
    logic       spl;
    logic [7:0] irq;
    logic [7:0] e_out;
    logic [7:0] e_oe;
    logic [7:0] e_gate;
    logic [7:0] e_in;
    logic [7:0] e_pull;
    logic [3:0] req;
  } vec_t;

  // Captured in run: out A5, oe F3, per-select 03. Live during the mode: out 5A, oe 0F.
  localparam vec_t VECS [11] = '{
    '{3'd0, 1'b0, 8'h00, 8'h0A, 8'h0F, 8'hFF, 8'hFF, 8'h0F, 4'd1},  // R1 R2 R9 R10
    '{3'd1, 1'b0, 8'h00, 8'hA2, 8'hF3, 8'hFF, 8'hFF, 8'h00, 4'd4},  // R4 sleep
    '{3'd1, 1'b1, 8'hFF, 8'hA2, 8'hF3, 8'hFF, 8'hFF, 8'h00, 4'd4},  // R4 hiz ignored
    '{3'd2, 1'b0, 8'h00, 8'hA1, 8'hF3, 8'h00, 8'h00, 8'h00, 4'd5},  // R5 stop hold
    '{3'd2, 1'b0, 8'hFF, 8'hA1, 8'hF3, 8'h12, 8'h12, 8'h00, 4'd7},  // R7 irq pads
    '{3'd2, 1'b0, 8'hED, 8'hA1, 8'hF3, 8'h00, 8'h00, 8'h00, 4'd7},  // R7 non-irq ignored
    '{3'd2, 1'b1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 4'd6},  // R6 stop hiz
    '{3'd3, 1'b1, 8'h12, 8'h00, 8'h00, 8'h12, 8'h12, 8'h00, 4'd6},  // R6 watch hiz
    '{3'd4, 1'b0, 8'h00, 8'hA1, 8'hF3, 8'h00, 8'h00, 8'h00, 4'd5},  // R5 timebase
    '{3'd7, 1'b0, 8'h00, 8'hA1, 8'hF3, 8'h00, 8'h00, 8'h00, 4'd5},  // R5 reserved code
    '{3'd3, 1'b0, 8'h12, 8'hA1, 8'hF3, 8'h12, 8'h12, 8'h00, 4'd11}  // R11 codes 11/00
  };

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input logic [7:0] o, oe, g, i, p);
    chk(req, "pad_out", pad_out, o);
    chk(req, "pad_oe", pad_oe, oe);
    chk(req, "pad_gate_en", pad_gate_en, g);
    chk(req, "pad_in_en", pad_in_en, i);
    chk(req, "pad_pull_en", pad_pull_en, p);
  endtask

  task automatic drive_live(input logic [7:0] pe, po, pt, dr, pr);
    per_out_en = pe; per_out = po; port_out = pt; port_dir = dr; pull_req = pr;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R8: reset state with live drive requested
    drive_live(8'h03, 8'h01, 8'hA5, 8'hF0, 8'hFF);
    repeat (3) @(negedge clk);
    #1 chk_all("R8", 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00);
    @(negedge clk) rst = 1'b0;

    foreach (VECS[k]) begin
      @(negedge clk);
      mode = 3'd0; pin_hiz_sel = 1'b0; irq_sel = '0;
      drive_live(8'h03, 8'h01, 8'hA5, 8'hF0, 8'hFF);
      @(negedge clk);
      mode = VECS[k].md; pin_hiz_sel = VECS[k].spl; irq_sel = VECS[k].irq;
      drive_live(8'h03, 8'h02, 8'h5A, 8'h0F, 8'hFF);
      #1 chk_all($sformatf("R%0d", VECS[k].req), VECS[k].e_out, VECS[k].e_oe,
                 VECS[k].e_gate, VECS[k].e_in, VECS[k].e_pull);
    end

    // R12: peripheral disabled in last run cycle, raised again during stop
    @(negedge clk);
    mode = 3'd0; pin_hiz_sel = 1'b0; irq_sel = '0;
    drive_live(8'h00, 8'h00, 8'hFF, 8'h0F, 8'h00);
    @(negedge clk);
    mode = 3'd2;
    drive_live(8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF);
    #1 chk("R12", "pad_oe", pad_oe, 8'h0F);
    chk("R12", "pad_out", pad_out, 8'h0F);

    // R3: frozen across edges, live again on return to run
    drive_live(8'hAA, 8'h55, 8'h00, 8'hF0, 8'h00);
    repeat (3) @(negedge clk);
    #1 chk("R3", "pad_oe frozen", pad_oe, 8'h0F);
    chk("R3", "pad_out frozen", pad_out, 8'h0F);
    @(negedge clk);
    mode = 3'd0;
    drive_live(8'h00, 8'h00, 8'h3C, 8'hFF, 8'h00);
    #1 chk("R3", "pad_out live", pad_out, 8'h3C);
    chk("R1", "pad_oe live", pad_oe, 8'hFF);

    // R8: reset clears held values; stop entered straight out of reset
    @(negedge clk);
    drive_live(8'h03, 8'h01, 8'hA5, 8'hF0, 8'hFF);
    @(negedge clk);
    rst = 1'b1; mode = 3'd2;
    #1 chk_all("R8", 8'h00, 8'h00, 8'hFF, 8'h00, 8'h00);
    @(negedge clk);
    rst = 1'b0;
    #1 chk("R8", "pad_oe after reset", pad_oe, 8'h00);
    chk("R8", "pad_out after reset", pad_out, 8'h00);
    chk("R7", "pad_gate_en after reset", pad_gate_en, 8'h00);

    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule